// File: doc/BRIEF.md
# Strided Address Sequencer

This block produces the byte addresses for one side of a DMA transfer, either the read side or the write side. A job is loaded with a single-cycle start pulse. The pulse carries a start address, a total byte count, a beat-size code, a movement mode and, optionally, a block length and a skip distance for strided transfers. Once loaded, the block offers one address per beat on a valid/ready handshake. It flags the final beat and pulses `done` once the byte count has been consumed.

The block only sequences addresses. Moving the data, the bus protocol and decoding descriptors are the job of neighbouring logic. A start pulse is taken only while the block is idle. Each beat reports the full beat width, so the last beat of a length that is not a multiple of the beat may cover fewer useful bytes than it reports.

Top module: `stride_agen`

## Requirements
- R1: `beat_bytes` reports the beat width given by the latched size code: code 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8.
- R2: With stride mode off and movement code 0, each accepted beat raises the address by the beat width.
- R3: With stride mode off and movement code 1, each accepted beat lowers the address by the beat width.
- R4: With stride mode off and movement code 2, the address stays at the start address for every beat.
- R5: With stride mode off and movement code 3, the address rises by the beat width but wraps inside an aligned window of four beats. The window base is the start address with its low log2(4×width) bits cleared.
- R6: With stride mode on, the movement code is ignored. Beats inside a block rise by the beat width. A block spans `cmd_blk` beats, and a value of 0 counts as 1. The first beat of each new block is the previous block's first address plus `cmd_stride` bytes.
- R7: With stride mode off, `cmd_blk` and `cmd_stride` have no effect on the addresses produced.
- R8: A job of N bytes produces exactly ceil(N / width) beats. `beat_last` is high only on the beat whose remaining count is at most the width.
- R9: `done` is high for exactly one cycle: the cycle after the last beat is accepted. `beat_valid` is low in that cycle.
- R10: A start with a byte count of zero produces no beat and raises `done` for one cycle, in the cycle after the start.
- R11: While `beat_valid` is high and `beat_ready` is low, `beat_valid`, `beat_addr` and `beat_last` hold their values.
- R12: After reset `beat_valid` and `done` are low. A start pulse while a job is in progress is ignored and does not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Load a job (taken only while idle) |
| cmd_addr | input | AW (32) | First byte address |
| cmd_count | input | CW (22) | Total byte count |
| cmd_size | input | 2 | Beat-size code |
| cmd_mode | input | 2 | Movement code: 0 up, 1 down, 2 fixed, 3 wrapping burst |
| cmd_stride_en | input | 1 | Enable strided blocks |
| cmd_blk | input | BW (14) | Beats per block in stride mode |
| cmd_stride | input | BW (14) | Byte distance between block starts |
| beat_valid | output | 1 | A beat address is offered |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | AW (32) | Address of the offered beat |
| beat_bytes | output | 4 | Width of the offered beat in bytes |
| beat_last | output | 1 | Offered beat is the final one |
| done | output | 1 | One-cycle pulse after the job ends |

## Verification
The first beat is offered in the cycle after the start pulse is sampled. Each later address appears in the cycle after the beat before it is accepted. `done` rises in the cycle after the last accepted beat, or in the cycle after a zero-length start, and falls the cycle after that. The bench changes `beat_ready` just after each falling edge and samples one nanosecond later. It counts accepted beats itself, so it knows which sample is the first one after an accepting edge. It compares every offered beat with a closed-form address for beat k rather than with a step-by-step model.

// File: rtl/stride_agen_pkg.sv
package stride_agen_pkg;

  typedef enum logic [1:0] {
    MV_UP   = 2'd0,
    MV_DOWN = 2'd1,
    MV_FIX  = 2'd2,
    MV_WRAP = 2'd3
  } move_e;

  localparam int unsigned BEATS_PER_WRAP = 4;

  // Beat width in bytes from the 2-bit size code.
  function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/stride_agen_count.sv
module stride_agen_count #(
  parameter int unsigned CW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] count_i,
  input  logic [3:0]    bytes_i,
  input  logic          take_i,
  output logic          last_o
);

  logic [CW-1:0] rem_q;
  logic [CW-1:0] width_ext;

  assign width_ext = {{(CW-4){1'b0}}, bytes_i};
  assign last_o    = (rem_q <= width_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= count_i;
    end else if (take_i) begin
      rem_q <= last_o ? '0 : (rem_q - width_ext);
    end
  end

  AST_REM_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !last_o) |=> (rem_q != '0)); // R8

endmodule

// File: rtl/stride_agen_step.sv
module stride_agen_step
  import stride_agen_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned BW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic          take_i,
  input  move_e         mode_i,
  input  logic          sen_i,
  input  logic [BW-1:0] blk_i,
  input  logic [BW-1:0] stride_i,
  input  logic [3:0]    bytes_i,
  output logic [AW-1:0] addr_o
);

  localparam int unsigned PAD = AW - 4;

  function automatic logic [AW-1:0] wrap_mask(input logic [3:0] b);
    logic [AW-1:0] w;
    w = {{PAD{1'b0}}, b} * AW'(BEATS_PER_WRAP);
    return w - AW'(1);
  endfunction

  function automatic logic [AW-1:0] move_next(input logic [AW-1:0] a,
                                              input move_e m,
                                              input logic [3:0] b);
    logic [AW-1:0] st;
    logic [AW-1:0] msk;
    logic [AW-1:0] r;
    st  = {{PAD{1'b0}}, b};
    msk = wrap_mask(b);
    case (m)
      MV_UP:   r = a + st;
      MV_DOWN: r = a - st;
      MV_FIX:  r = a;
      default: r = (a & ~msk) | ((a + st) & msk);
    endcase
    return r;
  endfunction

  logic [AW-1:0] addr_q;
  logic [AW-1:0] base_q;
  logic [BW-1:0] cnt_q;
  logic [BW:0]   blk_beats;
  logic [BW:0]   cnt_inc;
  logic          blk_end;
  logic [AW-1:0] next_base;
  logic [AW-1:0] win_mask;

  assign blk_beats = (blk_i == '0) ? {{BW{1'b0}}, 1'b1} : {1'b0, blk_i};
  assign cnt_inc   = {1'b0, cnt_q} + {{BW{1'b0}}, 1'b1};
  assign blk_end   = (cnt_inc >= blk_beats);
  assign next_base = base_q + {{(AW-BW){1'b0}}, stride_i};
  assign win_mask  = wrap_mask(bytes_i);
  assign addr_o    = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= start_i;
      base_q <= start_i;
      cnt_q  <= '0;
    end else if (take_i) begin
      if (sen_i) begin
        if (blk_end) begin
          cnt_q  <= '0;
          base_q <= next_base;
          addr_q <= next_base;
        end else begin
          cnt_q  <= cnt_inc[BW-1:0];
          addr_q <= addr_q + {{PAD{1'b0}}, bytes_i};
        end
      end else begin
        addr_q <= move_next(addr_q, mode_i, bytes_i);
      end
    end
  end

  AST_FIXED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !sen_i && mode_i == MV_FIX) |=> (addr_q == $past(addr_q))); // R4

  AST_WRAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !sen_i && mode_i == MV_WRAP)
      |=> ((addr_q & ~win_mask) == ($past(addr_q) & ~win_mask))); // R5

  AST_BLOCK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && sen_i && blk_end) |=> (addr_q == base_q)); // R6

endmodule

// File: rtl/stride_agen.sv
module stride_agen
  import stride_agen_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 22,
  parameter int unsigned BW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_addr,
  input  logic [CW-1:0] cmd_count,
  input  logic [1:0]    cmd_size,
  input  logic [1:0]    cmd_mode,
  input  logic          cmd_stride_en,
  input  logic [BW-1:0] cmd_blk,
  input  logic [BW-1:0] cmd_stride,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [AW-1:0] beat_addr,
  output logic [3:0]    beat_bytes,
  output logic          beat_last,
  output logic          done
);

  logic          busy_q;
  logic          done_q;
  logic [1:0]    size_q;
  move_e         mode_q;
  logic          sen_q;
  logic [BW-1:0] blk_q;
  logic [BW-1:0] stride_q;

  // Named internal events for the assertions.
  logic          accept_cmd;
  logic          take;
  logic          last_take;
  logic          empty_cmd;
  logic          last_w;
  logic [3:0]    bytes_w;

  assign accept_cmd = cmd_start && !busy_q;
  assign empty_cmd  = accept_cmd && (cmd_count == '0);
  assign take       = busy_q && beat_ready;
  assign last_take  = take && last_w;
  assign bytes_w    = size_to_bytes(size_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= '0;
      mode_q   <= MV_UP;
      sen_q    <= 1'b0;
      blk_q    <= '0;
      stride_q <= '0;
    end else if (accept_cmd) begin
      size_q   <= cmd_size;
      mode_q   <= move_e'(cmd_mode);
      sen_q    <= cmd_stride_en;
      blk_q    <= cmd_blk;
      stride_q <= cmd_stride;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept_cmd) begin
      busy_q <= !empty_cmd;
      done_q <= empty_cmd;
    end else if (last_take) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
    end
  end

  stride_agen_count #(.CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept_cmd),
    .count_i (cmd_count),
    .bytes_i (size_to_bytes(accept_cmd ? cmd_size : size_q)),
    .take_i  (take),
    .last_o  (last_w)
  );

  stride_agen_step #(.AW(AW), .BW(BW)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept_cmd),
    .start_i  (cmd_addr),
    .take_i   (take),
    .mode_i   (mode_q),
    .sen_i    (sen_q),
    .blk_i    (blk_q),
    .stride_i (stride_q),
    .bytes_i  (bytes_w),
    .addr_o   (beat_addr)
  );

  assign beat_valid = busy_q;
  assign beat_bytes = bytes_w;
  assign beat_last  = busy_q && last_w;
  assign done       = done_q;

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready)
      |=> (beat_valid && $stable(beat_addr) && $stable(beat_last))); // R11

  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> (done && !beat_valid)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_EMPTY_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    empty_cmd |=> (done && !beat_valid)); // R10

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && beat_valid && !beat_ready) |=> $stable(beat_addr)); // R12

  AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> $onehot0(beat_bytes) && (beat_bytes != 4'd0)); // R1

endmodule

// File: tb/stride_agen_tb.sv
`timescale 1ns/1ps
module stride_agen_tb;

  typedef struct packed {
    logic [31:0] addr;
    logic [21:0] count;
    logic [1:0]  size;
    logic [1:0]  mode;
    logic        sen;
    logic [13:0] blk;
    logic [13:0] stride;
    logic [15:0] nbeats;
  } job_t;

  localparam int NJOBS = 11;
  localparam job_t JOBS [NJOBS] = '{
    '{32'h0000_1000, 22'd16, 2'd2, 2'd0, 1'b0, 14'd0, 14'd0,     16'd4},  // R2
    '{32'h0000_2000, 22'd10, 2'd1, 2'd1, 1'b0, 14'd0, 14'd0,     16'd5},  // R3
    '{32'h0000_3000, 22'd7,  2'd0, 2'd2, 1'b0, 14'd0, 14'd0,     16'd7},  // R4
    '{32'h0000_400C, 22'd32, 2'd1, 2'd3, 1'b0, 14'd0, 14'd0,     16'd16}, // R5
    '{32'h0000_5000, 22'd24, 2'd2, 2'd0, 1'b1, 14'd2, 14'h0040,  16'd6},  // R6
    '{32'h0000_6000, 22'd10, 2'd3, 2'd0, 1'b0, 14'd0, 14'd0,     16'd2},  // R8
    '{32'h0000_7000, 22'd12, 2'd2, 2'd0, 1'b0, 14'd3, 14'h0100,  16'd3},  // R7
    '{32'h0000_8000, 22'd6,  2'd0, 2'd1, 1'b1, 14'd0, 14'h0010,  16'd6},  // R6
    '{32'h0000_9004, 22'd8,  2'd2, 2'd3, 1'b0, 14'd0, 14'd0,     16'd2},  // R5
    '{32'h0000_A018, 22'd32, 2'd3, 2'd3, 1'b0, 14'd0, 14'd0,     16'd4},  // R5
    '{32'h0000_B000, 22'd1,  2'd3, 2'd2, 1'b0, 14'd0, 14'd0,     16'd1}   // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [21:0] cmd_count = '0;
  logic [1:0]  cmd_size = '0;
  logic [1:0]  cmd_mode = '0;
  logic        cmd_stride_en = 1'b0;
  logic [13:0] cmd_blk = '0;
  logic [13:0] cmd_stride = '0;
  logic        beat_ready = 1'b0;
  logic        beat_valid;
  logic [31:0] beat_addr;
  logic [3:0]  beat_bytes;
  logic        beat_last;
  logic        done;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  stride_agen u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .cmd_size(cmd_size), .cmd_mode(cmd_mode),
    .cmd_stride_en(cmd_stride_en), .cmd_blk(cmd_blk), .cmd_stride(cmd_stride),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_bytes(beat_bytes), .beat_last(beat_last), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Closed-form address of beat k, written from the requirements.
  function automatic logic [31:0] expect_addr(input job_t j, input int k);
    int w, win, nb;
    logic [31:0] base, off;
    w = 1 << j.size;
    if (j.sen) begin
      nb = (j.blk == 0) ? 1 : int'(j.blk);
      return j.addr + 32'((k / nb) * int'(j.stride)) + 32'((k % nb) * w);
    end
    case (j.mode)
      2'd0: return j.addr + 32'(k * w);
      2'd1: return j.addr - 32'(k * w);
      2'd2: return j.addr;
      default: begin
        win  = 4 * w;
        base = j.addr & ~32'(win - 1);
        off  = j.addr & 32'(win - 1);
        return base + ((off + 32'(k * w)) % 32'(win));
      end
    endcase
  endfunction

  task automatic run_job(input int idx);
    job_t j;
    int k, guard, cyc;
    bit fin;
    j = JOBS[idx];
    @(negedge clk);
    cmd_addr = j.addr; cmd_count = j.count; cmd_size = j.size; cmd_mode = j.mode;
    cmd_stride_en = j.sen; cmd_blk = j.blk; cmd_stride = j.stride; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    k = 0; guard = 0; cyc = 0; fin = 1'b0;
    while (!fin && guard < 2000) begin
      guard++;
      cyc++;
      beat_ready = ((cyc + idx) % 3) != 1;
      // R12: a second start in the middle of job 0 must be ignored.
      if (idx == 0 && k == 1) begin
        cmd_start = 1'b1; cmd_addr = 32'hDEAD_0000; cmd_count = 22'd4; cmd_mode = 2'd2;
      end else begin
        cmd_start = 1'b0;
      end
      #1;
      if (beat_valid) begin
        chk(beat_addr == expect_addr(j, k), $sformatf("R2-R7 addr job%0d beat%0d", idx, k),
            beat_addr, expect_addr(j, k));
        chk(beat_bytes == 4'(1 << j.size), "R1 beat width", beat_bytes, 1 << j.size);
        chk(beat_last == (k == int'(j.nbeats) - 1), "R8 last flag", beat_last, k == int'(j.nbeats) - 1);
        chk(done == 1'b0, "R9 done low while busy", done, 0);
        if (beat_ready) begin
          k++;
          if (beat_last) begin
            @(negedge clk);
            cmd_start = 1'b0;
            #1;
            chk(done == 1'b1, "R9 done after last", done, 1);
            chk(beat_valid == 1'b0, "R9 valid low with done", beat_valid, 0);
            @(negedge clk);
            #1;
            chk(done == 1'b0, "R9 done single cycle", done, 0);
            fin = 1'b1;
          end
        end
      end
      if (!fin) @(negedge clk);
    end
    cmd_start = 1'b0;
    beat_ready = 1'b0;
    chk(fin, "R8 job finished", fin, 1);
    chk(k == int'(j.nbeats), "R8 beat count", k, j.nbeats);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(beat_valid == 1'b0, "R12 reset valid", beat_valid, 0);
    chk(done == 1'b0, "R12 reset done", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(beat_valid == 1'b0 && done == 1'b0, "R12 idle after reset", {beat_valid, done}, 0);

    for (int i = 0; i < NJOBS; i++) run_job(i);

    // R10: zero-length job.
    @(negedge clk);
    cmd_addr = 32'h0000_C000; cmd_count = 22'd0; cmd_size = 2'd2; cmd_mode = 2'd0;
    cmd_stride_en = 1'b0; cmd_start = 1'b1; beat_ready = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    #1;
    chk(done == 1'b1, "R10 done after empty start", done, 1);
    chk(beat_valid == 1'b0, "R10 no beat", beat_valid, 0);
    @(negedge clk);
    #1;
    chk(done == 1'b0 && beat_valid == 1'b0, "R10 quiet afterwards", {done, beat_valid}, 0);

    // R11: long stall keeps the first beat steady.
    @(negedge clk);
    cmd_addr = 32'h0000_D000; cmd_count = 22'd8; cmd_size = 2'd2; cmd_start = 1'b1; beat_ready = 1'b0;
    @(negedge clk);
    cmd_start = 1'b0;
    for (int s = 0; s < 5; s++) begin
      #1;
      chk(beat_valid && beat_addr == 32'h0000_D000 && !beat_last, "R11 stall hold", beat_addr, 32'h0000_D000);
      @(negedge clk);
    end
    beat_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(beat_addr == 32'h0000_D004 && beat_last, "R11 release", beat_addr, 32'h0000_D004);
    @(negedge clk);
    #1;
    chk(done == 1'b1, "R9 done after released job", done, 1);
    beat_ready = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule